// File: doc/BRIEF.md
# CCD Vertical Transfer Phase Sequencer

This block generates the clock pattern that moves one line of charge from the imaging area of a three-phase full-frame CCD into its serial register. It drives the three vertical phase clocks, the transfer gate and a level that holds the horizontal phase-1 clock. Every gap between two consecutive edges is a count of system clock cycles. The defaults correspond to the microsecond figures of the sensor's timing at a 10 MHz clock.

A controller pulses `start` once per output row. At that moment the block captures two inputs. `mode_mpp` picks one of two fixed edge orderings: normal timing, or multi-pinned-phase timing with inverted phases. `bin_2x` asks for two line transfers back to back, so that two lines add up in the serial register before readout. `busy` covers the whole operation and `done` marks its end. A row counter raises `frame_done` once a full frame has been moved. A full frame is ROWS operations, or ROWS/2 operations when binning.

Top module: `ccd_vxfer_seq`

## Requirements
- R1: After reset, `busy`, `done` and `frame_done` are low. `hclk_en` and `xfer_gate` are high, `vph1` and `vph2` are high and `vph3` is low. The row counter is cleared.
- R2: With `mode_mpp`=0 captured, `hclk_en` falls in the first cycle after the accepting edge. Further edges follow in this order: vph1 falls, vph3 rises, vph2 falls, vph1 rises, vph3 falls, vph2 rises, xfer_gate falls, hclk_en rises. The gaps are CYC_2U6, CYC_2U6, CYC_2U6, CYC_5U2, CYC_1U4, CYC_1U4, CYC_4U6 and CYC_2U6 cycles (defaults 26, 26, 26, 52, 14, 14, 46, 26). Only one output changes per cycle.
- R3: With `mode_mpp`=1 captured, the idle phase levels are all low. `hclk_en` falls in the first cycle after the accepting edge. Further edges follow in this order: vph2 rises, vph3 rises, vph2 falls, vph1 rises, vph3 falls, xfer_gate falls, hclk_en rises. The gaps are CYC_2U6, CYC_5U2, CYC_2U6, CYC_2U6, CYC_2U8, CYC_4U6 and CYC_2U6 cycles (defaults 26, 52, 26, 26, 28, 46, 26).
- R4: CYC_2U6 cycles after `hclk_en` rises, a restore interval of CYC_2U6 cycles begins. In it `xfer_gate` returns high and the phases return to the idle levels of the captured mode, so in the multi-pinned-phase mode vph1 falls. With defaults, `busy` stays high for 282 cycles in either mode.
- R5: `mode_mpp` and `bin_2x` are sampled only on the edge that accepts `start`. `start` has no effect while `busy` is high.
- R6: With `bin_2x`=1 captured, a second full transfer follows the restore interval at once. Its `hclk_en` fall comes in the cycle after restore ends, and `xfer_gate` is high during restore. `done` comes only after the second transfer, so `busy` lasts 564 cycles with defaults.
- R7: Each completed operation advances the row counter. When it reaches ROWS for a non-binning operation, or ROWS/2 for a binning one, `frame_done` rises together with `done` and the counter clears. `frame_done` stays high until the next accepted `start`.
- R8: `done` is a single-cycle pulse. It is raised in the cycle where `busy` first reads low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request one row operation |
| mode_mpp | input | 1 | 0 = normal timing, 1 = multi-pinned-phase timing |
| bin_2x | input | 1 | 1 = two line transfers per operation |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| frame_done | output | 1 | All rows of the frame transferred |
| hclk_en | output | 1 | Horizontal phase-1 hold, low while vertical transfer runs |
| xfer_gate | output | 1 | Transfer gate into the serial register |
| vph1 | output | 1 | Vertical phase 1 |
| vph2 | output | 1 | Vertical phase 2 |
| vph3 | output | 1 | Vertical phase 3 |

## Verification
Cycle t=1 is the first cycle after the edge that accepts `start`, and every result is counted from there. The first edge shows at t=1 and edge k at 1 plus the sum of the k preceding gaps. The restore interval starts at t=257, and `done` is high at t=283 for a single transfer or at t=565 for a binned pair. The bench counts negedges from the accepting edge and samples each output level both in its first cycle and in the last cycle of the level before it, so an off-by-one gap shows at one of the two. Late `start` pulses and changes on the mode pins are applied at fixed t values, and their absence of effect is then read at an edge whose level would differ between the modes.

// File: rtl/ccd_vxfer_seq.sv
module ccd_vxfer_seq #(
  parameter int CYC_2U6 = 26,
  parameter int CYC_5U2 = 52,
  parameter int CYC_1U4 = 14,
  parameter int CYC_4U6 = 46,
  parameter int CYC_2U8 = 28,
  parameter int ROWS    = 330
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic mode_mpp,
  input  logic bin_2x,
  output logic busy,
  output logic done,
  output logic frame_done,
  output logic hclk_en,
  output logic xfer_gate,
  output logic vph1,
  output logic vph2,
  output logic vph3
);
  localparam int M1   = (CYC_2U6 > CYC_5U2) ? CYC_2U6 : CYC_5U2;
  localparam int M2   = (M1 > CYC_1U4) ? M1 : CYC_1U4;
  localparam int M3   = (M2 > CYC_4U6) ? M2 : CYC_4U6;
  localparam int CMAX = (M3 > CYC_2U8) ? M3 : CYC_2U8;
  localparam int CW   = $clog2(CMAX + 1);
  localparam int RW   = $clog2(ROWS + 1);
  localparam int ROWS_BIN = ROWS / 2;

  logic          busy_q, done_q, frame_q, mpp_q, bin_q, pass_q;
  logic [3:0]    s_q;
  logic [CW-1:0] cnt_q, dur;
  logic [RW-1:0] row_q;
  logic [3:0]    s_rest;
  logic          step_end, in_seq, last_pass;
  logic [RW-1:0] row_goal;

  assign s_rest    = mpp_q ? 4'd8 : 4'd9;
  assign step_end  = busy_q && (cnt_q == dur - 1'b1);
  assign in_seq    = busy_q && (s_q != s_rest);
  assign last_pass = !bin_q || pass_q;
  assign row_goal  = bin_q ? RW'(ROWS_BIN) : RW'(ROWS);

  always_comb begin
    dur = CW'(CYC_2U6);
    if (mpp_q) begin
      case (s_q)
        4'd1:    dur = CW'(CYC_5U2);
        4'd4:    dur = CW'(CYC_2U8);
        4'd5:    dur = CW'(CYC_4U6);
        default: dur = CW'(CYC_2U6);
      endcase
    end else begin
      case (s_q)
        4'd3:       dur = CW'(CYC_5U2);
        4'd4, 4'd5: dur = CW'(CYC_1U4);
        4'd6:       dur = CW'(CYC_4U6);
        default:    dur = CW'(CYC_2U6);
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; done_q <= 1'b0; frame_q <= 1'b0;
      mpp_q  <= 1'b0; bin_q  <= 1'b0; pass_q  <= 1'b0;
      s_q    <= '0;   cnt_q  <= '0;   row_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          busy_q  <= 1'b1;
          s_q     <= '0;
          cnt_q   <= '0;
          mpp_q   <= mode_mpp;
          bin_q   <= bin_2x;
          pass_q  <= 1'b0;
          frame_q <= 1'b0;
        end
      end else if (step_end) begin
        cnt_q <= '0;
        if (s_q == s_rest) begin
          if (last_pass) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
            if (row_q + 1'b1 >= row_goal) begin
              row_q   <= '0;
              frame_q <= 1'b1;
            end else begin
              row_q <= row_q + 1'b1;
            end
          end else begin
            pass_q <= 1'b1;
            s_q    <= '0;
          end
        end else begin
          s_q <= s_q + 1'b1;
        end
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  always_comb begin
    hclk_en   = 1'b1;
    xfer_gate = 1'b1;
    vph1      = !mpp_q;
    vph2      = !mpp_q;
    vph3      = 1'b0;
    if (in_seq) begin
      if (mpp_q) begin
        hclk_en   = !(s_q <= 4'd6);
        xfer_gate = !(s_q == 4'd6 || s_q == 4'd7);
        vph1      = (s_q >= 4'd4 && s_q <= 4'd7);
        vph2      = (s_q >= 4'd1 && s_q <= 4'd2);
        vph3      = (s_q >= 4'd2 && s_q <= 4'd4);
      end else begin
        hclk_en   = !(s_q <= 4'd7);
        xfer_gate = !(s_q == 4'd7 || s_q == 4'd8);
        vph1      = !(s_q >= 4'd1 && s_q <= 4'd3);
        vph2      = !(s_q >= 4'd3 && s_q <= 4'd5);
        vph3      = (s_q >= 4'd2 && s_q <= 4'd4);
      end
    end
  end

  assign busy       = busy_q;
  assign done       = done_q;
  assign frame_done = frame_q;

  logic [4:0] lev;
  assign lev = {hclk_en, xfer_gate, vph1, vph2, vph3};

  p_idle_rest_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (hclk_en && xfer_gate));
  p_single_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !mpp_q) |-> ($countones(lev ^ $past(lev)) <= 1));
  p_tg_under_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(xfer_gate) |-> !hclk_en);
  p_mode_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(mpp_q) && $stable(bin_q)));
  p_frame_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_done) |-> done);
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_on_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
endmodule

// File: tb/tb_ccd_vxfer_seq.sv
module tb_ccd_vxfer_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, mode_mpp = 1'b0, bin_2x = 1'b0;
  logic busy, done, frame_done, hclk_en, xfer_gate, vph1, vph2, vph3;
  int nchk = 0, nerr = 0, t = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  ccd_vxfer_seq #(.ROWS(4)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_mpp(mode_mpp), .bin_2x(bin_2x),
    .busy(busy), .done(done), .frame_done(frame_done), .hclk_en(hclk_en),
    .xfer_gate(xfer_gate), .vph1(vph1), .vph2(vph2), .vph3(vph3));

  // {mpp, t, {hclk_en, xfer_gate, vph1, vph2, vph3}}
  localparam logic [14:0] VEC [38] = '{
    {1'b0, 9'd1,   5'b01110}, {1'b0, 9'd26,  5'b01110}, {1'b0, 9'd27,  5'b01010},
    {1'b0, 9'd52,  5'b01010}, {1'b0, 9'd53,  5'b01011}, {1'b0, 9'd78,  5'b01011},
    {1'b0, 9'd79,  5'b01001}, {1'b0, 9'd130, 5'b01001}, {1'b0, 9'd131, 5'b01101},
    {1'b0, 9'd144, 5'b01101}, {1'b0, 9'd145, 5'b01100}, {1'b0, 9'd158, 5'b01100},
    {1'b0, 9'd159, 5'b01110}, {1'b0, 9'd204, 5'b01110}, {1'b0, 9'd205, 5'b00110},
    {1'b0, 9'd230, 5'b00110}, {1'b0, 9'd231, 5'b10110}, {1'b0, 9'd256, 5'b10110},
    {1'b0, 9'd257, 5'b11110}, {1'b0, 9'd282, 5'b11110},
    {1'b1, 9'd1,   5'b01000}, {1'b1, 9'd26,  5'b01000}, {1'b1, 9'd27,  5'b01010},
    {1'b1, 9'd78,  5'b01010}, {1'b1, 9'd79,  5'b01011}, {1'b1, 9'd104, 5'b01011},
    {1'b1, 9'd105, 5'b01001}, {1'b1, 9'd130, 5'b01001}, {1'b1, 9'd131, 5'b01101},
    {1'b1, 9'd158, 5'b01101}, {1'b1, 9'd159, 5'b01100}, {1'b1, 9'd204, 5'b01100},
    {1'b1, 9'd205, 5'b00100}, {1'b1, 9'd230, 5'b00100}, {1'b1, 9'd231, 5'b10100},
    {1'b1, 9'd256, 5'b10100}, {1'b1, 9'd257, 5'b11000}, {1'b1, 9'd282, 5'b11000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s t=%0d act=%0h exp=%0h", req, t, act, exp);
    end
  endtask

  task automatic go(input logic m, input logic b);
    start = 1'b1; mode_mpp = m; bin_2x = b;
    @(negedge clk);
    start = 1'b0;
    t = 1;
  endtask

  task automatic wait_to(input int target);
    while (t < target) begin
      @(negedge clk);
      t++;
    end
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nerr++; nchk++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    do_reset;
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 frame_done", frame_done, 0);
    chk("R1 levels", {hclk_en, xfer_gate, vph1, vph2, vph3}, 5'b11110);

    for (int m = 0; m < 2; m++) begin
      go(m[0], 1'b0);
      for (int i = 0; i < 38; i++) begin
        if (VEC[i][14] == m[0]) begin
          wait_to(int'(VEC[i][13:5]));
          chk(m == 0 ? "R2 levels" : "R3 levels",
              {hclk_en, xfer_gate, vph1, vph2, vph3}, VEC[i][4:0]);
        end
      end
      chk("R4 busy at 282", busy, 1);
      chk("R8 done early", done, 0);
      wait_to(283);
      chk("R4 busy end", busy, 0);
      chk("R8 done", done, 1);
      wait_to(284);
      chk("R8 done width", done, 0);
    end
    chk("R4 mpp idle", {hclk_en, xfer_gate, vph1, vph2, vph3}, 5'b11000);

    // R5: late start with other mode while busy
    go(1'b0, 1'b0);
    wait_to(50);
    start = 1'b1; mode_mpp = 1'b1; bin_2x = 1'b1;
    wait_to(51);
    start = 1'b0;
    wait_to(79);
    chk("R5 mode held", {hclk_en, xfer_gate, vph1, vph2, vph3}, 5'b01001);
    wait_to(283);
    chk("R5 no restart", done, 1);

    // R6: binned pair
    go(1'b0, 1'b1);
    wait_to(282);
    chk("R6 tg high between", {busy, hclk_en, xfer_gate}, 3'b111);
    wait_to(283);
    chk("R6 second pass", {busy, done, hclk_en}, 3'b100);
    wait_to(564);
    chk("R6 still busy", {busy, done}, 2'b10);
    wait_to(565);
    chk("R6 done", {busy, done}, 2'b01);

    // R1/R7: reset clears row counter and frame flag
    go(1'b0, 1'b0);
    wait_to(283);
    do_reset;
    chk("R1 frame cleared", frame_done, 0);
    for (int k = 1; k <= 4; k++) begin
      go(1'b0, 1'b0);
      wait_to(283);
      chk("R7 frame normal", frame_done, (k == 4) ? 1 : 0);
    end
    go(1'b0, 1'b1);
    chk("R7 frame clear on start", frame_done, 0);
    wait_to(565);
    chk("R7 frame bin half", frame_done, 0);
    go(1'b1, 1'b1);
    wait_to(565);
    chk("R7 frame bin", {done, frame_done}, 2'b11);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule